// File: doc/BRIEF.md
# PCIe Root Port INTx Interrupt Queue

This block gathers legacy INTx assert and deassert events for a PCIe root port and holds them in a small circular queue until software takes them. Each event carries a lane number (0 to 3) and a level, and is accepted in the cycle `evt_valid` is high. Software uses a 32-bit register port addressed by byte offset. It can look at the oldest queued event, remove it, clear pending-interrupt bits, set an interrupt mask, drive a bridge-enable output and see the link state. A single level output `irq` tells the host CPU that a pending cause is enabled.

Reads have no side effects. `reg_rdata` always shows the register selected by `reg_addr`, computed from the current register state. A write is taken in the clock cycle where `reg_wr` is high. An event and a register write may arrive in the same cycle, and both take effect.

The queue occupancy is tracked by a state machine with three states:
- `Q_EMPTY`: nothing is held.
- `Q_HOLD`: between one entry and one below capacity.
- `Q_FULL`: the capacity is reached.

Its transitions are:
- `fill_first` (`Q_EMPTY`→`Q_HOLD`): an event is accepted.
- `fill_last` (`Q_HOLD`→`Q_FULL`): an event is accepted with no pop while one slot remains.
- `drain_last` (`Q_HOLD`→`Q_EMPTY`): a pop with no event while one entry remains.
- `drain_one` (`Q_FULL`→`Q_HOLD`): any pop.

Every other combination of event and pop keeps the state.

Top module: `rp_intx_queue`

## Requirements
- R1: After reset the following are all zero: the queue, the decode register, the mask register, the overflow bit and `bridge_enable`. In that state every offset reads 0, except offset 0x144 when `link_up` is high.
- R2: Reading offset 0x158 returns the head entry as a word with these fields: bit 31 = 1 (valid), bit 29 = event level, bits 28:27 = lane, and all other bits 0. Offset 0x15C always reads 0.
- R3: The queue is first-in first-out. Reading 0x158 or 0x15C does not remove the head entry. With the queue empty, 0x158 reads 0.
- R4: A write of any value to 0x158 or to 0x15C removes the head entry. When the queue is empty, such a write changes nothing.
- R5: The queue holds at most SLOTS-1 entries (15 by default). An event that arrives while it is full is dropped, even when a pop happens in the same cycle. A drop sets bit 19 of offset 0x148, and that bit clears only on reset.
- R6: Decode offset 0x138, bit 16: this bit is set by every accepted event. A write with data bit 16 = 1 clears it. While the queue is not empty, the bit is set again in the same cycle as the write, so it cannot be cleared. Bit 17 (MSI) has no source and reads 0.
- R7: Mask offset 0x13C is a 32-bit read/write register. `irq` is high exactly when decode bit 16 and mask bit 16 are both 1.
- R8: Offset 0x148 behaves as follows:
  - Bit 0 is read/write and drives `bridge_enable`.
  - Bit 18 reads 1 while the queue is not empty.
  - Bit 19 is the overflow flag.
  - Writes to every other bit, and to bits 18 and 19, are ignored.
- R9: Offset 0x144 reads `link_up` at bit 11 and 0 elsewhere. Writes to it are ignored.
- R10: Any offset not listed above reads 0, and writes to it change no register.
- R11: A write or an accepted event captured at a clock edge is visible on `reg_rdata`, `irq` and `bridge_enable` straight after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | INTx event present this cycle |
| evt_lane | input | 2 | Lane of the event (0 to 3) |
| evt_level | input | 1 | 1 = assert, 0 = deassert |
| link_up | input | 1 | Link state, shown at 0x144 bit 11 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Data of the register at `reg_addr` |
| irq | output | 1 | Level interrupt to the host |
| bridge_enable | output | 1 | Value of 0x148 bit 0 |

## Verification
Each register is one flop stage from its input, and every output is combinational from those registers. So any write or event sampled at an edge must show on `reg_rdata`, `irq` and `bridge_enable` in the cycle right after it. Changes on `reg_addr` or `link_up` show on `reg_rdata` with no clock at all. The bench drives inputs on the falling edge and advances its reference model at each rising edge. It compares every output 2 ns after that rising edge, which is exactly the cycle in which the result is due. Directed checks set `reg_addr` on a falling edge and sample 1 ns later, while the state is unchanged since the previous rising edge.

// File: rtl/rpq_pkg.sv
package rpq_pkg;
    // Register byte offsets
    localparam logic [11:0] OFS_DECODE = 12'h138;
    localparam logic [11:0] OFS_MASK   = 12'h13C;
    localparam logic [11:0] OFS_PHY    = 12'h144;
    localparam logic [11:0] OFS_CTRL   = 12'h148;
    localparam logic [11:0] OFS_WORD1  = 12'h158;
    localparam logic [11:0] OFS_WORD2  = 12'h15C;

    // Bit positions decoded by software
    localparam int BIT_INTX   = 16;
    localparam int BIT_LINK   = 11;
    localparam int BIT_BREN   = 0;
    localparam int BIT_NEMPTY = 18;
    localparam int BIT_OVF    = 19;
    localparam int BIT_VALID  = 31;
    localparam int BIT_LEVEL  = 29;
    localparam int LANE_LO    = 27;
    localparam int LANE_W     = 2;

    typedef struct packed {
        logic              level;
        logic [LANE_W-1:0] lane;
    } intx_evt_t;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_HOLD  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_t;
endpackage

// File: rtl/rpq_fifo.sv
module rpq_fifo
    import rpq_pkg::*;
#(
    parameter int SLOTS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  intx_evt_t push_data_i,
    input  logic      pop_i,
    output logic      empty_o,
    output logic      hold_nxt_o,
    output logic      drop_o,
    output intx_evt_t head_o
);
    localparam int PTR_W = $clog2(SLOTS);
    localparam int CAP   = SLOTS - 1;

    q_state_t   state_q, state_d;
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, count_q;
    intx_evt_t  mem [SLOTS];
    logic       push_ok, pop_ok;

    assign push_ok = push_i && (state_q != Q_FULL);
    assign pop_ok  = pop_i  && (state_q != Q_EMPTY);

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(SLOTS - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: if (push_ok) state_d = Q_HOLD;                        // fill_first
            Q_HOLD: begin
                if (push_ok && !pop_ok && count_q == PTR_W'(CAP - 1))
                    state_d = Q_FULL;                                      // fill_last
                else if (pop_ok && !push_ok && count_q == PTR_W'(1))
                    state_d = Q_EMPTY;                                     // drain_last
            end
            Q_FULL:  if (pop_ok) state_d = Q_HOLD;                         // drain_one
            default: state_d = Q_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // Pointers and occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= wrap_inc(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= wrap_inc(rd_ptr_q);
            if (push_ok && !pop_ok)      count_q <= count_q + PTR_W'(1);
            else if (pop_ok && !push_ok) count_q <= count_q - PTR_W'(1);
        end
    end

    // Entry storage
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr_q] <= push_data_i;
    end

    // Outputs
    always_comb begin
        empty_o    = (state_q == Q_EMPTY);
        hold_nxt_o = (state_d != Q_EMPTY);
        drop_o     = push_i && (state_q == Q_FULL);
        head_o     = mem[rd_ptr_q];
    end

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= PTR_W'(CAP));

    a_r4_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_EMPTY && pop_i && !push_i) |=> (state_q == Q_EMPTY && $stable(rd_ptr_q)));

    a_r5_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_FULL && !pop_i) |=> (state_q == Q_FULL && $stable(wr_ptr_q)));
endmodule

// File: rtl/rpq_regs.sv
module rpq_regs
    import rpq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              link_up_i,
    input  logic              fifo_empty_i,
    input  logic              fifo_hold_nxt_i,
    input  logic              fifo_drop_i,
    input  intx_evt_t         fifo_head_i,
    output logic              pop_o,
    output logic [31:0]       rdata_o,
    output logic              irq_o,
    output logic              bridge_en_o
);
    logic        dec_q, ovf_q, bren_q;
    logic [31:0] mask_q;
    logic        wr_dec, wr_mask, wr_ctrl;

    assign wr_dec  = wr_i && (addr_i == ADDR_W'(OFS_DECODE));
    assign wr_mask = wr_i && (addr_i == ADDR_W'(OFS_MASK));
    assign wr_ctrl = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
    assign pop_o   = wr_i && ((addr_i == ADDR_W'(OFS_WORD1)) || (addr_i == ADDR_W'(OFS_WORD2)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q  <= 1'b0;
            mask_q <= '0;
            ovf_q  <= 1'b0;
            bren_q <= 1'b0;
        end else begin
            dec_q <= (dec_q && !(wr_dec && wdata_i[BIT_INTX])) || fifo_hold_nxt_i;
            if (wr_mask)     mask_q <= wdata_i;
            if (wr_ctrl)     bren_q <= wdata_i[BIT_BREN];
            if (fifo_drop_i) ovf_q  <= 1'b1;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_W'(OFS_DECODE): rdata_o[BIT_INTX] = dec_q;
            ADDR_W'(OFS_MASK):   rdata_o = mask_q;
            ADDR_W'(OFS_PHY):    rdata_o[BIT_LINK] = link_up_i;
            ADDR_W'(OFS_CTRL): begin
                rdata_o[BIT_BREN]   = bren_q;
                rdata_o[BIT_NEMPTY] = !fifo_empty_i;
                rdata_o[BIT_OVF]    = ovf_q;
            end
            ADDR_W'(OFS_WORD1): if (!fifo_empty_i) begin
                rdata_o[BIT_VALID]                  = 1'b1;
                rdata_o[BIT_LEVEL]                  = fifo_head_i.level;
                rdata_o[LANE_LO +: LANE_W]          = fifo_head_i.lane;
            end
            default: rdata_o = '0;
        endcase
        irq_o       = dec_q && mask_q[BIT_INTX];
        bridge_en_o = bren_q;
    end

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    a_r6_decode_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty_i |-> dec_q);

    a_r8_bridge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(bridge_en_o));
endmodule

// File: rtl/rp_intx_queue.sv
module rp_intx_queue
    import rpq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SLOTS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [1:0]        evt_lane,
    input  logic              evt_level,
    input  logic              link_up,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              bridge_enable
);
    intx_evt_t evt, head;
    logic      pop, empty, hold_nxt, drop;

    assign evt.level = evt_level;
    assign evt.lane  = evt_lane;

    rpq_fifo #(.SLOTS(SLOTS)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (evt_valid),
        .push_data_i (evt),
        .pop_i       (pop),
        .empty_o     (empty),
        .hold_nxt_o  (hold_nxt),
        .drop_o      (drop),
        .head_o      (head)
    );

    rpq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_i            (reg_wr),
        .addr_i          (reg_addr),
        .wdata_i         (reg_wdata),
        .link_up_i       (link_up),
        .fifo_empty_i    (empty),
        .fifo_hold_nxt_i (hold_nxt),
        .fifo_drop_i     (drop),
        .fifo_head_i     (head),
        .pop_o           (pop),
        .rdata_o         (reg_rdata),
        .irq_o           (irq),
        .bridge_en_o     (bridge_enable)
    );
endmodule

// File: tb/test_rp_intx_queue.sv
`timescale 1ns/1ps
module test_rp_intx_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_lane = '0;
    logic        evt_level = 1'b0;
    logic        link_up = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, bridge_enable;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    rp_intx_queue i_rp_intx_queue (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_lane(evt_lane),
        .evt_level(evt_level), .link_up(link_up), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .bridge_enable(bridge_enable)
    );

    // Behavioural reference model
    int          mq[$];
    bit          m_dec, m_ovf, m_bren;
    bit [31:0]   m_mask;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_dec = 0; m_ovf = 0; m_bren = 0; m_mask = 0;
        end else begin
            bit full, popn;
            full = (mq.size() == 15);
            popn = reg_wr && (reg_addr == 12'h158 || reg_addr == 12'h15C) && mq.size() > 0;
            if (evt_valid && full) m_ovf = 1;
            if (reg_wr && reg_addr == 12'h138 && reg_wdata[16]) m_dec = 0;
            if (reg_wr && reg_addr == 12'h13C) m_mask = reg_wdata;
            if (reg_wr && reg_addr == 12'h148) m_bren = reg_wdata[0];
            if (popn) void'(mq.pop_front());
            if (evt_valid && !full) mq.push_back({evt_level, evt_lane});
            if (mq.size() > 0) m_dec = 1;
        end
    end

    function automatic [31:0] exp_rd(input [11:0] a);
        case (a)
            12'h138: return {15'd0, m_dec, 16'd0};
            12'h13C: return m_mask;
            12'h144: return {20'd0, link_up, 11'd0};
            12'h148: return {12'd0, m_ovf, mq.size() > 0, 17'd0, m_bren};
            12'h158: if (mq.size() > 0)
                         return 32'h8000_0000 | (32'(mq[0][2]) << 29) | (32'(mq[0][1:0]) << 27);
                     else return 0;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input [11:0] a);
        case (a)
            12'h138: return "R6";
            12'h13C: return "R7";
            12'h144: return "R9";
            12'h148: return "R8";
            12'h158, 12'h15C: return "R2";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input [31:0] got, input [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare against the model on every clock
    always @(posedge clk) begin
        #2;
        if (!done) begin
            chk(tag_of(reg_addr), reg_rdata, exp_rd(reg_addr));
            chk("R7 irq", {31'd0, irq}, {31'd0, m_dec & m_mask[16]});
            chk("R8 bridge_enable", {31'd0, bridge_enable}, {31'd0, m_bren});
        end
    end

    task automatic wr(input [11:0] a, input [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic ev(input [1:0] lane, input bit lvl);
        @(negedge clk); evt_valid = 1; evt_lane = lane; evt_level = lvl;
        @(negedge clk); evt_valid = 0;
    endtask

    task automatic peek(input string tag, input [11:0] a, input [31:0] exp);
        @(negedge clk); reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        peek("R1 decode", 12'h138, 0);
        peek("R1 mask",   12'h13C, 0);
        peek("R1 ctrl",   12'h148, 0);
        peek("R1 word1",  12'h158, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        wr(12'h13C, 32'h0001_0000);
        // R11: event visible straight after its capturing edge
        @(negedge clk); evt_valid = 1; evt_lane = 0; evt_level = 1;
        @(posedge clk); #1;
        chk("R11 irq", {31'd0, irq}, 1);
        @(negedge clk); evt_valid = 0;
        ev(3, 0); ev(2, 1);
        peek("R2 word1 lane0 assert", 12'h158, 32'hA000_0000);
        peek("R2 word2", 12'h15C, 0);
        peek("R3 peek keeps head", 12'h158, 32'hA000_0000);
        wr(12'h15C, 0);
        peek("R3 R4 order after pop via word2", 12'h158, 32'h9800_0000);
        wr(12'h158, 32'h1234);
        peek("R4 pop via word1", 12'h158, 32'hB000_0000);
        wr(12'h138, 32'hFFFF_FFFF);
        peek("R6 decode forced while queued", 12'h138, 32'h0001_0000);
        wr(12'h158, 0);
        peek("R3 empty read", 12'h158, 0);
        peek("R6 decode sticky after drain", 12'h138, 32'h0001_0000);
        wr(12'h138, 32'h0001_0000);
        peek("R6 decode cleared", 12'h138, 0);
        chk("R7 irq low", {31'd0, irq}, 0);
        wr(12'h158, 0);
        peek("R4 empty pop ignored", 12'h148, 0);

        // R5 overflow
        for (int i = 0; i < 17; i++) ev(2'(i), 1'(i >> 2));
        peek("R5 full with overflow", 12'h148, 32'h000C_0000);
        @(negedge clk); evt_valid = 1; evt_lane = 1; reg_wr = 1; reg_addr = 12'h158;
        @(negedge clk); evt_valid = 0; reg_wr = 0;
        for (int i = 0; i < 13; i++) wr(12'h15C, 0);
        peek("R5 one entry left", 12'h148, 32'h000C_0000);
        wr(12'h15C, 0);
        peek("R5 drop under concurrent pop", 12'h148, 32'h0008_0000);

        // R6 event together with clear write
        @(negedge clk); evt_valid = 1; evt_lane = 1; reg_wr = 1; reg_addr = 12'h138; reg_wdata = 32'h0001_0000;
        @(negedge clk); evt_valid = 0; reg_wr = 0;
        peek("R6 event wins over clear", 12'h138, 32'h0001_0000);
        peek("R2 lane1 deassert", 12'h158, 32'h8800_0000);

        // R7 mask
        wr(12'h13C, 32'h0002_0000);
        chk("R7 mask bit17 gives no irq", {31'd0, irq}, 0);
        peek("R7 mask read", 12'h13C, 32'h0002_0000);
        wr(12'h13C, 32'hFFFF_FFFF);
        chk("R7 irq high", {31'd0, irq}, 1);

        // R8 control
        wr(12'h148, 32'hFFFF_FFFF);
        peek("R8 ctrl write", 12'h148, 32'h000C_0001);
        wr(12'h148, 0);
        peek("R8 overflow kept", 12'h148, 32'h000C_0000);

        // R9 link
        link_up = 1;
        peek("R9 link up", 12'h144, 32'h0000_0800);
        wr(12'h144, 0);
        peek("R9 write ignored", 12'h144, 32'h0000_0800);
        link_up = 0;
        peek("R9 link down", 12'h144, 0);

        // R10 undefined offsets
        wr(12'h200, 32'hFFFF_FFFF);
        peek("R10 undefined read", 12'h200, 0);
        peek("R10 undefined 0x140", 12'h140, 0);
        peek("R10 mask untouched", 12'h13C, 32'hFFFF_FFFF);

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule